// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block runs the complete erase of one block of an on-chip flash array without processor involvement. On a start command it raises the software-enable strobe and selects one block. It then drives an erase attempt: erase-setup, the erase pulse, and the release of both. A verify pass follows, which reads back every word of the block. Each control edge is followed by its own programmable wait. The watchdog-enable output is high while an erase pulse can be in flight. If a word does not read as all ones, the block starts another erase attempt. This repeats until the block verifies or the attempt limit is used up. No preprogramming pass to all zeros is made.

All wait counts, the attempt limit, the block select and the block address bounds are captured when a start is accepted. They can then change freely during the run. A controller that needs several blocks erased issues one command per block. A wait value of v holds the corresponding phase for v+1 clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, every flash strobe, wdt_en_o and blk_en_o are low.
- R2: A start whose blk_sel_i does not have exactly one bit set gives a fail_o pulse in the next cycle. busy_o stays low and no strobe rises.
- R3: An accepted start runs the phases in this order, each lasting its wait count plus one cycle: software-enable on (x), one arm cycle, erase-setup on (y), erase pulse on (z), erase pulse off (α), erase-setup off (β), erase-verify on (γ). busy_o stays high from the cycle after start through the final wait.
- R4: wdt_en_o is high in the arm cycle and in every cycle from erase-setup on through erase-setup off. It is low during verify.
- R5: Verify visits addresses from blk_start_i upward, one word at a time. For each word it gives a one-cycle dummy-write strobe wr_o, then a wait of ε+1 cycles, then a one-cycle rd_o. A word passes only when rd_data_i is all ones.
- R6: A failing word ends the verify pass: erase-verify goes off and a wait of η+1 cycles follows. Then, if the attempt count is below the limit, a new attempt starts at erase-setup.
- R7: When the attempt count equals the limit (a limit of 0 counts as 1), a failing verify leads to software-enable off, a wait of θ+1 cycles, and a one-cycle fail_o pulse. Exactly that many erase pulses have been issued.
- R8: When the last word passes, erase-verify goes off, η+1 cycles follow, then software-enable goes off, θ+1 cycles follow, and done_o pulses for one cycle as busy_o falls. done_o and fail_o are never high together.
- R9: A start_i pulse while busy_o is high is ignored and leaves the running sequence unchanged.
- R10: Wait counts, limit, select and bounds are sampled at the accepted start. Later changes on those inputs do not alter the running sequence.
- R11: blk_en_o equals the captured select from the arm cycle until software-enable goes off, and is zero otherwise.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, accepted when idle |
| blk_sel_i | input | BLK_W | One-hot block select |
| blk_start_i | input | ADDR_W | First word address of the block |
| blk_end_i | input | ADDR_W | Last word address of the block |
| wait_swe_on_i | input | WAIT_W | Wait after software-enable on (x) |
| wait_esu_on_i | input | WAIT_W | Wait after erase-setup on (y) |
| wait_erase_i | input | WAIT_W | Erase pulse length (z) |
| wait_erase_off_i | input | WAIT_W | Wait after erase pulse off (α) |
| wait_esu_off_i | input | WAIT_W | Wait after erase-setup off (β) |
| wait_ev_on_i | input | WAIT_W | Wait after erase-verify on (γ) |
| wait_dwr_i | input | WAIT_W | Wait between dummy write and read (ε) |
| wait_ev_off_i | input | WAIT_W | Wait after erase-verify off (η) |
| wait_swe_off_i | input | WAIT_W | Wait after software-enable off (θ) |
| try_lim_i | input | TRY_W | Maximum number of erase attempts (N) |
| rd_data_i | input | DATA_W | Verify read data |
| swe_o | output | 1 | Software-enable strobe |
| esu_o | output | 1 | Erase-setup strobe |
| erase_o | output | 1 | Erase pulse strobe |
| ev_o | output | 1 | Erase-verify strobe |
| wdt_en_o | output | 1 | Watchdog enable |
| blk_en_o | output | BLK_W | Block enable to the array |
| addr_o | output | ADDR_W | Verify word address |
| wr_o | output | 1 | Dummy-write (0xFF) strobe |
| rd_o | output | 1 | Verify read strobe |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle pulse: block erased and verified |
| fail_o | output | 1 | One-cycle pulse: rejected select or attempts exhausted |

## Verification
The bench targets a block that verifies on the first pulse, blocks that need several pulses, and a block that reaches the limit exactly. It also covers a block that runs out of attempts, including a limit of one. A design that retried one time too many or too few would show the wrong number of erase pulses and the wrong busy length. A failing word placed mid-block and at the last address catches a verify that does not stop at the first bad word, or one that stops a word early. Two invalid selects (none set, two set) must fail without raising software-enable. A start pulse with new wait values during a run must not change its timing or its block enable, which catches late sampling and a start that is not ignored.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
package fes_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SWE_ON,
    ST_ARM,
    ST_ESU_ON,
    ST_ERS_ON,
    ST_ERS_OFF,
    ST_ESU_OFF,
    ST_EV_ON,
    ST_DWR,
    ST_DWAIT,
    ST_RD,
    ST_EV_OFF_OK,
    ST_EV_OFF_NG,
    ST_SWE_OFF_OK,
    ST_SWE_OFF_NG
  } fes_state_e;

  localparam int NUM_WAIT   = 9;
  localparam int WI_SWE     = 0;
  localparam int WI_ESU     = 1;
  localparam int WI_ERS     = 2;
  localparam int WI_ERS_OFF = 3;
  localparam int WI_ESU_OFF = 4;
  localparam int WI_EV      = 5;
  localparam int WI_DWR     = 6;
  localparam int WI_EV_OFF  = 7;
  localparam int WI_SWE_OFF = 8;

  function automatic logic is_wait_state(fes_state_e s);
    return !(s inside {ST_IDLE, ST_ARM, ST_DWR, ST_RD});
  endfunction

endpackage

// File: rtl/fes_wait_timer.sv
`timescale 1ns/1ps
module fes_wait_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] val_i,
  output logic              zero_o
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_timer_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_timer_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));

endmodule

// File: rtl/fes_blk_sel.sv
`timescale 1ns/1ps
module fes_blk_sel #(
  parameter int BLK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] sel_i,
  input  logic             cap_i,
  output logic             ok_o,
  output logic [BLK_W-1:0] sel_q_o
);

  logic [BLK_W-1:0] sel_q;

  // exactly one bit: nonzero and no second bit
  assign ok_o = (sel_i != '0) && ((sel_i & (sel_i - 1'b1)) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= '0;
    else if (cap_i) sel_q <= sel_i;
  end

  assign sel_q_o = sel_q;

  assert_sel_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && ok_o) |=> ($countones(sel_q) == 1));

  assert_sel_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && ($countones(sel_i) != 1)) |-> !ok_o);

endmodule

// File: rtl/fes_addr_walk.sv
`timescale 1ns/1ps
module fes_addr_walk #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              load_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [ADDR_W-1:0] start_q, end_q, addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (cap_i) begin
      start_q <= start_i;
      end_q   <= end_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= start_q;
    else if (inc_i)   addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == end_q);

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (addr_q == $past(addr_q) + 1'b1));

  assert_addr_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_q == $past(start_q)));

  assert_no_step_past_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);

endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 16,
  parameter int TRY_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  blk_sel_i,
  input  logic [ADDR_W-1:0] blk_start_i,
  input  logic [ADDR_W-1:0] blk_end_i,
  input  logic [WAIT_W-1:0] wait_swe_on_i,
  input  logic [WAIT_W-1:0] wait_esu_on_i,
  input  logic [WAIT_W-1:0] wait_erase_i,
  input  logic [WAIT_W-1:0] wait_erase_off_i,
  input  logic [WAIT_W-1:0] wait_esu_off_i,
  input  logic [WAIT_W-1:0] wait_ev_on_i,
  input  logic [WAIT_W-1:0] wait_dwr_i,
  input  logic [WAIT_W-1:0] wait_ev_off_i,
  input  logic [WAIT_W-1:0] wait_swe_off_i,
  input  logic [TRY_W-1:0]  try_lim_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              swe_o,
  output logic              esu_o,
  output logic              erase_o,
  output logic              ev_o,
  output logic              wdt_en_o,
  output logic [BLK_W-1:0]  blk_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);

  localparam logic [TRY_W-1:0] TRY_ONE = TRY_W'(1);

  fes_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cfg_in [NUM_WAIT];
  logic [WAIT_W-1:0] cfg_q  [NUM_WAIT];
  logic [WAIT_W-1:0] tmr_val;
  logic              tmr_load, tmr_zero;
  logic [TRY_W-1:0]  try_q, lim_q;
  logic              idle, sel_ok, accept, accept_ok, reject;
  logic              word_ok, last, retry;
  logic              addr_load, addr_inc;
  logic [BLK_W-1:0]  sel_q;
  logic              done_q, fail_q;

  assign cfg_in[WI_SWE]     = wait_swe_on_i;
  assign cfg_in[WI_ESU]     = wait_esu_on_i;
  assign cfg_in[WI_ERS]     = wait_erase_i;
  assign cfg_in[WI_ERS_OFF] = wait_erase_off_i;
  assign cfg_in[WI_ESU_OFF] = wait_esu_off_i;
  assign cfg_in[WI_EV]      = wait_ev_on_i;
  assign cfg_in[WI_DWR]     = wait_dwr_i;
  assign cfg_in[WI_EV_OFF]  = wait_ev_off_i;
  assign cfg_in[WI_SWE_OFF] = wait_swe_off_i;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && start_i;
  assign accept_ok = accept && sel_ok;
  assign reject    = accept && !sel_ok;
  assign word_ok   = (rd_data_i == '1);
  assign retry     = (try_q < lim_q);

  fes_blk_sel #(.BLK_W(BLK_W)) i_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (blk_sel_i),
    .cap_i   (accept_ok),
    .ok_o    (sel_ok),
    .sel_q_o (sel_q)
  );

  fes_wait_timer #(.WAIT_W(WAIT_W)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  fes_addr_walk #(.ADDR_W(ADDR_W)) i_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (accept_ok),
    .start_i (blk_start_i),
    .end_i   (blk_end_i),
    .load_i  (addr_load),
    .inc_i   (addr_inc),
    .addr_o  (addr_o),
    .last_o  (last)
  );

  // configuration snapshot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WAIT; i++) cfg_q[i] <= '0;
      lim_q <= TRY_ONE;
    end else if (accept_ok) begin
      for (int i = 0; i < NUM_WAIT; i++) cfg_q[i] <= cfg_in[i];
      lim_q <= (try_lim_i == '0) ? TRY_ONE : try_lim_i;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (accept_ok) state_d = ST_SWE_ON;
      ST_SWE_ON:     if (tmr_zero)  state_d = ST_ARM;
      ST_ARM:                       state_d = ST_ESU_ON;
      ST_ESU_ON:     if (tmr_zero)  state_d = ST_ERS_ON;
      ST_ERS_ON:     if (tmr_zero)  state_d = ST_ERS_OFF;
      ST_ERS_OFF:    if (tmr_zero)  state_d = ST_ESU_OFF;
      ST_ESU_OFF:    if (tmr_zero)  state_d = ST_EV_ON;
      ST_EV_ON:      if (tmr_zero)  state_d = ST_DWR;
      ST_DWR:                       state_d = ST_DWAIT;
      ST_DWAIT:      if (tmr_zero)  state_d = ST_RD;
      ST_RD: begin
        if (!word_ok)   state_d = ST_EV_OFF_NG;
        else if (last)  state_d = ST_EV_OFF_OK;
        else            state_d = ST_DWR;
      end
      ST_EV_OFF_OK:  if (tmr_zero)  state_d = ST_SWE_OFF_OK;
      ST_EV_OFF_NG:  if (tmr_zero)  state_d = retry ? ST_ESU_ON : ST_SWE_OFF_NG;
      ST_SWE_OFF_OK: if (tmr_zero)  state_d = ST_IDLE;
      ST_SWE_OFF_NG: if (tmr_zero)  state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  // timer is loaded on entry to each wait phase
  always_comb begin
    tmr_load = (state_d != state_q) && is_wait_state(state_d);
    unique case (state_d)
      ST_SWE_ON:                    tmr_val = cfg_in[WI_SWE];
      ST_ESU_ON:                    tmr_val = cfg_q[WI_ESU];
      ST_ERS_ON:                    tmr_val = cfg_q[WI_ERS];
      ST_ERS_OFF:                   tmr_val = cfg_q[WI_ERS_OFF];
      ST_ESU_OFF:                   tmr_val = cfg_q[WI_ESU_OFF];
      ST_EV_ON:                     tmr_val = cfg_q[WI_EV];
      ST_DWAIT:                     tmr_val = cfg_q[WI_DWR];
      ST_EV_OFF_OK, ST_EV_OFF_NG:   tmr_val = cfg_q[WI_EV_OFF];
      ST_SWE_OFF_OK, ST_SWE_OFF_NG: tmr_val = cfg_q[WI_SWE_OFF];
      default:                      tmr_val = '0;
    endcase
  end

  assign addr_load = (state_d == ST_EV_ON) && (state_q != ST_EV_ON);
  assign addr_inc  = (state_q == ST_RD) && word_ok && !last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      try_q <= '0;
    else if (state_q == ST_ARM)
      try_q <= TRY_ONE;
    else if (state_q == ST_EV_OFF_NG && state_d == ST_ESU_ON)
      try_q <= try_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= (state_q == ST_SWE_OFF_OK) && tmr_zero;
      fail_q <= ((state_q == ST_SWE_OFF_NG) && tmr_zero) || reject;
    end
  end

  assign busy_o   = !idle;
  assign swe_o    = !(state_q inside {ST_IDLE, ST_SWE_OFF_OK, ST_SWE_OFF_NG});
  assign esu_o    = state_q inside {ST_ESU_ON, ST_ERS_ON, ST_ERS_OFF};
  assign erase_o  = (state_q == ST_ERS_ON);
  assign ev_o     = state_q inside {ST_EV_ON, ST_DWR, ST_DWAIT, ST_RD};
  assign wdt_en_o = state_q inside {ST_ARM, ST_ESU_ON, ST_ERS_ON, ST_ERS_OFF, ST_ESU_OFF};
  assign wr_o     = (state_q == ST_DWR);
  assign rd_o     = (state_q == ST_RD);
  assign blk_en_o = (swe_o && state_q != ST_SWE_ON) ? sel_q : '0;
  assign done_o   = done_q;
  assign fail_o   = fail_q;

  assert_erase_in_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> (esu_o && swe_o && wdt_en_o));

  assert_erase_after_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_o) |-> $past(esu_o));

  assert_wdt_off_verify_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |-> !wdt_en_o);

  assert_ev_excl_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |-> !esu_o);

  assert_rw_in_verify_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o || rd_o) |-> (ev_o && !(wr_o && rd_o)));

  assert_try_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(state_q inside {ST_SWE_ON, ST_ARM})) |-> (try_q >= TRY_ONE && try_q <= lim_q));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_done_fail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_quiet_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(swe_o || esu_o || erase_o || ev_o || wdt_en_o || wr_o || rd_o));

  assert_busy_from_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_blk_en_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_en_o != '0) |-> (swe_o && $countones(blk_en_o) == 1));

endmodule

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;

  localparam int BLK_W = 8, ADDR_W = 16, WAIT_W = 16, TRY_W = 8, DATA_W = 16;

  typedef struct {
    int is_fail;
    int busy;
    int pulses;
    int writes;
    int wdt;
    int blk;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [BLK_W-1:0]  sel = '0;
  logic [ADDR_W-1:0] a_lo = '0, a_hi = '0;
  logic [WAIT_W-1:0] w_x = '0, w_y = '0, w_z = '0, w_a = '0, w_b = '0,
                     w_g = '0, w_e = '0, w_h = '0, w_t = '0;
  logic [TRY_W-1:0]  lim = '0;
  logic [DATA_W-1:0] rdat;
  logic swe, esu, ers, ev, wdt, wr, rd, busy, done, fail;
  logic [BLK_W-1:0]  blk_en;
  logic [ADDR_W-1:0] addr;

  int n_chk = 0, n_bad = 0;
  int k_bad = 0, bad_addr = 0;
  logic [DATA_W-1:0] bad_val = 16'hFFFE;
  int m_busy = 0, m_pulses = 0, m_writes = 0, m_wdt = 0, m_blk = 0;
  logic prev_ers = 1'b0;
  int m_seen = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  assign rdat = (m_pulses < k_bad && int'(addr) == bad_addr) ? bad_val : '1;

  flash_erase_seq #(.BLK_W(BLK_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W),
                    .TRY_W(TRY_W), .DATA_W(DATA_W)) i_flash_erase_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_sel_i(sel),
    .blk_start_i(a_lo), .blk_end_i(a_hi),
    .wait_swe_on_i(w_x), .wait_esu_on_i(w_y), .wait_erase_i(w_z),
    .wait_erase_off_i(w_a), .wait_esu_off_i(w_b), .wait_ev_on_i(w_g),
    .wait_dwr_i(w_e), .wait_ev_off_i(w_h), .wait_swe_off_i(w_t),
    .try_lim_i(lim), .rd_data_i(rdat),
    .swe_o(swe), .esu_o(esu), .erase_o(ers), .ev_o(ev), .wdt_en_o(wdt),
    .blk_en_o(blk_en), .addr_o(addr), .wr_o(wr), .rd_o(rd),
    .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: gathers per-run observations, compares against queued expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) m_busy++;
      if (wdt) m_wdt++;
      if (wr) m_writes++;
      if (ers && !prev_ers) begin
        if (m_pulses == 0) m_blk = int'(blk_en);
        m_pulses++;
      end
      prev_ers = ers;
      if (done && fail) chk(0, "R8 done and fail together", 1, 0);
      if (done || fail) begin
        if (q.size() == 0) chk(0, "R9 unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(fail) == e.is_fail, "R7/R8 outcome fail flag", int'(fail), e.is_fail);
          chk(m_busy == e.busy, "R3 busy cycle count", m_busy, e.busy);
          chk(m_pulses == e.pulses, "R6 erase pulse count", m_pulses, e.pulses);
          chk(m_writes == e.writes, "R5 dummy write count", m_writes, e.writes);
          chk(m_wdt == e.wdt, "R4 watchdog-enabled cycles", m_wdt, e.wdt);
          chk(m_blk == e.blk, "R11 block enable at erase", m_blk, e.blk);
        end
        m_seen++;
        m_busy = 0; m_pulses = 0; m_writes = 0; m_wdt = 0; m_blk = 0;
      end
    end
  end

  task automatic run_job(input int s, input int lo, input int hi,
                         input int x, input int y, input int z, input int a, input int b,
                         input int g, input int e, input int h, input int t,
                         input int n, input int k, input int bad_off,
                         input bit disturb);
    exp_t ex;
    int len, att, fails, pass, lim_eff, seen0;
    bit onehot;
    len = hi - lo + 1;
    lim_eff = (n == 0) ? 1 : n;
    att = (k <= 1) ? 1 : k;
    pass = (att <= lim_eff) ? 1 : 0;
    if (pass == 0) att = lim_eff;
    fails = pass ? att - 1 : att;
    onehot = ($countones(s[BLK_W-1:0]) == 1);
    if (onehot) begin
      ex.is_fail = pass ? 0 : 1;
      ex.busy = (x + 1) + 1 + att * ((y+1) + (z+1) + (a+1) + (b+1) + (g+1) + (h+1))
              + fails * (bad_off + 1) * (e + 3) + (pass ? len * (e + 3) : 0) + (t + 1);
      ex.pulses = att;
      ex.writes = fails * (bad_off + 1) + (pass ? len : 0);
      ex.wdt = 1 + att * ((y+1) + (z+1) + (a+1) + (b+1));
      ex.blk = s;
    end else begin
      ex.is_fail = 1; ex.busy = 0; ex.pulses = 0; ex.writes = 0; ex.wdt = 0; ex.blk = 0;
    end
    q.push_back(ex);
    k_bad = k; bad_addr = lo + bad_off;
    sel = BLK_W'(s); a_lo = ADDR_W'(lo); a_hi = ADDR_W'(hi);
    w_x = WAIT_W'(x); w_y = WAIT_W'(y); w_z = WAIT_W'(z); w_a = WAIT_W'(a);
    w_b = WAIT_W'(b); w_g = WAIT_W'(g); w_e = WAIT_W'(e); w_h = WAIT_W'(h);
    w_t = WAIT_W'(t); lim = TRY_W'(n);
    seen0 = m_seen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R9/R10: new config and a second start during the run
      repeat (3) @(negedge clk);
      w_x = 7; w_y = 7; w_z = 7; w_a = 7; w_b = 7; w_g = 7; w_e = 7; w_h = 7; w_t = 7;
      lim = 9; sel = 8'h80; a_lo = 16'h0; a_hi = 16'h0020;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_seen == seen0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && !swe && blk_en == '0, "R11 quiet after run", int'(blk_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail, "R1 reset status", int'(busy), 0);
    chk(!swe && !esu && !ers && !ev && !wdt && !wr && !rd && blk_en == '0,
        "R1 reset strobes", int'({swe, esu, ers, ev, wdt, wr, rd}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: invalid selects
    run_job(8'h00, 16, 19, 1, 1, 1, 1, 1, 1, 1, 1, 1, 3, 0, 0, 0);
    run_job(8'h05, 16, 19, 1, 1, 1, 1, 1, 1, 1, 1, 1, 3, 0, 0, 0);
    // first-try pass, zero waits
    run_job(8'h01, 32, 35, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0);
    // R6: two attempts, mixed waits, failing word mid-block
    run_job(8'h04, 64, 71, 2, 1, 3, 0, 2, 1, 2, 1, 3, 4, 2, 3, 0);
    // R7: limit exhausted
    bad_val = 16'h7FFF;
    run_job(8'h10, 100, 105, 1, 0, 2, 1, 0, 3, 1, 2, 1, 3, 5, 1, 0);
    // R9/R10: disturbed run, single-word block
    bad_val = 16'hFFFE;
    run_job(8'h02, 200, 200, 3, 2, 1, 2, 1, 0, 2, 0, 2, 1, 1, 0, 1);
    // limit reached exactly, failing word at last address
    run_job(8'h40, 300, 303, 0, 1, 0, 1, 0, 1, 0, 1, 0, 2, 2, 3, 0);
    // R7: limit one, zero limit treated as one
    run_job(8'h20, 400, 402, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 2, 0, 0);
    run_job(8'h08, 500, 501, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 1, 0);
    chk(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule